// File: doc/BRIEF.md
# Frame Phase Offset Calculator

This block sits beside the slot sequencer of a time-slotted radio node. Each time a packet arrives during the active part of a frame, it turns the arrival moment into a signed phase error in clock cycles. The expected arrival is the start of the sender's slot plus a fixed transmit delay. The sender's slot is located relative to the receiver's own current slot by the slot-number difference carried in the packet. The error is that expected cycle minus the receiver's cycle counter at arrival. The error is clipped to the storable range and put into a small buffer that is kept in sorted order.

Once the active slots are over, the sequencer raises a calculate request. The block then reduces the frame's errors to one correction. If no packet arrived, the correction is zero. If the count is odd, it is the middle error. If the count is even, it is the mean of the two middle errors, truncated toward zero. A frame-start strobe empties the buffer for the next frame. Receptions beyond the buffer capacity are discarded and flagged.

Top module: `phase_offset_calc`

## Requirements
- R1: While reset is asserted and after it is released, `offset` is 0 and `offset_valid` and `rx_dropped` are 0.
- R2: A stored phase error equals (rx_slot − local_slot) × SLOT_LEN + TX_DELAY − local_cycle, where the slot numbers are unsigned and the result is signed (defaults SLOT_LEN = 1000, TX_DELAY = 40).
- R3: A phase error outside ±(2^(PE_W−1) − 1) is clipped to that bound (±2047 with defaults). The offset never leaves that range.
- R4: `offset_valid` is high for exactly the cycle after each cycle in which `calc_req` is high, and `offset` then shows the new result. In all other cycles `offset` keeps its value.
- R5: A calculation over a frame with no stored errors yields an offset of 0.
- R6: With an odd number of stored errors, the offset is the middle value in sorted order.
- R7: With an even number of stored errors, the offset is the sum of the two middle values divided by two, truncated toward zero (for example, −3 and −2 give −2).
- R8: The buffer holds at most DEPTH errors (default 8). A further `rx_strobe` in the same frame stores nothing, raises `rx_dropped` for the following cycle, and does not affect the offset.
- R9: `frame_start` empties the buffer. An `rx_strobe` in the same cycle as `frame_start` is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Empties the error buffer for a new frame |
| rx_strobe | input | 1 | One-cycle pulse on packet arrival |
| rx_slot | input | SLOT_W | Slot number carried in the received packet |
| local_slot | input | SLOT_W | Receiver's current slot number |
| local_cycle | input | CYC_W | Receiver's cycle count within the current slot |
| calc_req | input | 1 | Request to reduce the frame's errors to an offset |
| offset | output | PE_W | Signed per-frame correction in cycles |
| offset_valid | output | 1 | One-cycle pulse when a new offset is presented |
| rx_dropped | output | 1 | One-cycle pulse when a reception found the buffer full |

## Verification
Several properties are checked on every cycle: the timing of the valid pulse against the request, that the offset holds between results, that the fill count stays within capacity, that a drop only follows a strobe into a full buffer, that a frame start empties the buffer, that an empty frame yields zero, and that the offset stays within range. The arithmetic cannot be shown that way. The slot-difference correction, clipping, median selection for odd and even counts, rounding toward zero of negative means, and ignoring strobes that were dropped or that coincided with a frame start only show up in the bench's frames, whose results are compared against an independent model.

// File: rtl/poc_pkg.sv
package poc_pkg;

  // Clip a value into the symmetric range [-lim, lim].
  function automatic int clip(input int v, input int lim);
    if (v > lim) return lim;
    if (v < -lim) return -lim;
    return v;
  endfunction

  // Mean of two values, rounded toward zero (integer division semantics).
  function automatic int mid_mean(input int a, input int b);
    return (a + b) / 2;
  endfunction

endpackage

// File: rtl/poc_phase_err.sv
module poc_phase_err #(
  parameter int SLOT_W   = 8,
  parameter int SLOT_LEN = 1000,
  parameter int TX_DELAY = 40,
  parameter int CYC_W    = 10,
  parameter int PE_W     = 12
) (
  input  logic [SLOT_W-1:0]      rx_slot,
  input  logic [SLOT_W-1:0]      local_slot,
  input  logic [CYC_W-1:0]       local_cycle,
  output logic signed [PE_W-1:0] pe
);
  localparam int PE_MAX = 2 ** (PE_W - 1) - 1;

  int raw;

  always_comb begin
    // expected arrival (sender slot start + tx delay, in local frame) minus actual
    raw = (int'(rx_slot) - int'(local_slot)) * SLOT_LEN + TX_DELAY - int'(local_cycle);
    pe  = PE_W'(poc_pkg::clip(raw, PE_MAX));
  end

endmodule

// File: rtl/poc_sorted_buf.sv
module poc_sorted_buf #(
  parameter  int DEPTH = 8,
  parameter  int PE_W  = 12,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   wr_en,
  input  logic signed [PE_W-1:0] wr_val,
  output logic [CNT_W-1:0]       cnt,
  output logic signed [PE_W-1:0] ent [DEPTH]
);
  logic signed [PE_W-1:0] ent_q [DEPTH];
  logic signed [PE_W-1:0] ent_d [DEPTH];
  logic [CNT_W-1:0]       cnt_q;
  logic [DEPTH-1:0]       keep;

  // keep[i]: entry i is valid and not above the new value, so it stays put.
  // Because the buffer is ascending, keep is a prefix of ones.
  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_lane
      assign keep[i] = (CNT_W'(i) < cnt_q) && (ent_q[i] <= wr_val);
      if (i == 0) begin : g_head
        assign ent_d[i] = keep[i] ? ent_q[i] : wr_val;
      end else begin : g_body
        assign ent_d[i] = keep[i]   ? ent_q[i] :
                          keep[i-1] ? wr_val   : ent_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int k = 0; k < DEPTH; k++) ent_q[k] <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (wr_en) begin
      cnt_q <= cnt_q + CNT_W'(1);
      ent_q <= ent_d;
    end
  end

  assign cnt = cnt_q;
  assign ent = ent_q;

endmodule

// File: rtl/poc_median.sv
module poc_median #(
  parameter  int DEPTH = 8,
  parameter  int PE_W  = 12,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [CNT_W-1:0]       cnt,
  input  logic signed [PE_W-1:0] ent [DEPTH],
  output logic signed [PE_W-1:0] med
);
  logic [CNT_W-1:0]       lo_idx;
  logic [CNT_W-1:0]       hi_idx;
  logic signed [PE_W-1:0] lo_v;
  logic signed [PE_W-1:0] hi_v;

  always_comb begin
    lo_idx = (cnt - CNT_W'(1)) >> 1;
    hi_idx = cnt >> 1;
    lo_v   = '0;
    hi_v   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (CNT_W'(i) == lo_idx) lo_v = ent[i];
      if (CNT_W'(i) == hi_idx) hi_v = ent[i];
    end
    // odd count: lo_idx == hi_idx, so the mean is the middle value itself
    if (cnt == '0) med = '0;
    else           med = PE_W'(poc_pkg::mid_mean(int'(lo_v), int'(hi_v)));
  end

endmodule

// File: rtl/phase_offset_calc.sv
module phase_offset_calc #(
  parameter  int SLOT_W   = 8,
  parameter  int SLOT_LEN = 1000,
  parameter  int TX_DELAY = 40,
  parameter  int DEPTH    = 8,
  localparam int CYC_W    = $clog2(SLOT_LEN),
  localparam int PE_W     = CYC_W + 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   frame_start,
  input  logic                   rx_strobe,
  input  logic [SLOT_W-1:0]      rx_slot,
  input  logic [SLOT_W-1:0]      local_slot,
  input  logic [CYC_W-1:0]       local_cycle,
  input  logic                   calc_req,
  output logic signed [PE_W-1:0] offset,
  output logic                   offset_valid,
  output logic                   rx_dropped
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic signed [PE_W-1:0] pe;
  logic signed [PE_W-1:0] med;
  logic [CNT_W-1:0]       cnt_q;
  logic signed [PE_W-1:0] ent [DEPTH];
  logic                   buf_full;
  logic                   wr_en;
  logic                   drop_d, drop_q;
  logic                   valid_d, valid_q;
  logic signed [PE_W-1:0] offset_d, offset_q;

  poc_phase_err #(
    .SLOT_W(SLOT_W), .SLOT_LEN(SLOT_LEN), .TX_DELAY(TX_DELAY),
    .CYC_W(CYC_W), .PE_W(PE_W)
  ) err_i (
    .rx_slot(rx_slot), .local_slot(local_slot), .local_cycle(local_cycle), .pe(pe)
  );

  poc_sorted_buf #(.DEPTH(DEPTH), .PE_W(PE_W)) buf_i (
    .clk(clk), .rst_n(rst_n), .clr(frame_start), .wr_en(wr_en),
    .wr_val(pe), .cnt(cnt_q), .ent(ent)
  );

  poc_median #(.DEPTH(DEPTH), .PE_W(PE_W)) med_i (
    .cnt(cnt_q), .ent(ent), .med(med)
  );

  // next-state
  always_comb begin
    buf_full = (cnt_q == CNT_W'(DEPTH));
    wr_en    = rx_strobe && !frame_start && !buf_full;
    drop_d   = rx_strobe && !frame_start && buf_full;
    valid_d  = calc_req;
    offset_d = calc_req ? med : offset_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drop_q   <= 1'b0;
      valid_q  <= 1'b0;
      offset_q <= '0;
    end else begin
      drop_q   <= drop_d;
      valid_q  <= valid_d;
      offset_q <= offset_d;
    end
  end

  assign offset       = offset_q;
  assign offset_valid = valid_q;
  assign rx_dropped   = drop_q;

endmodule

// File: rtl/poc_checker.sv
module poc_checker #(
  parameter  int DEPTH = 8,
  parameter  int PE_W  = 12,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PE_MAX = 2 ** (PE_W - 1) - 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   frame_start,
  input logic                   rx_strobe,
  input logic                   calc_req,
  input logic [CNT_W-1:0]       cnt,
  input logic signed [PE_W-1:0] offset,
  input logic                   offset_valid,
  input logic                   rx_dropped
);
  p_valid_after_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    calc_req |=> offset_valid);

  p_valid_has_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    offset_valid |-> $past(calc_req));

  p_offset_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !offset_valid |-> $stable(offset));

  p_empty_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (offset_valid && $past(cnt) == '0) |-> offset == '0);

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH));

  p_drop_when_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dropped |-> ($past(rx_strobe) && $past(cnt) == CNT_W'(DEPTH)));

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> cnt == '0);

  p_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(offset) <= PE_MAX) && (int'(offset) >= -PE_MAX));

endmodule

bind phase_offset_calc poc_checker #(.DEPTH(DEPTH), .PE_W(PE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .rx_strobe(rx_strobe),
  .calc_req(calc_req), .cnt(cnt_q), .offset(offset),
  .offset_valid(offset_valid), .rx_dropped(rx_dropped)
);

// File: tb/phase_offset_calc_tb_top.sv
`timescale 1ns/1ps
module phase_offset_calc_tb_top;
  localparam int SLOT_LEN = 1000;
  localparam int TX_DELAY = 40;
  localparam int DEPTH    = 8;
  localparam int PE_MAX   = 2047;

  typedef struct packed {
    logic [7:0] rs;
    logic [7:0] ls;
    logic [9:0] lc;
    logic       last;
  } row_t;

  localparam int NROWS = 15;
  localparam row_t ROWS [NROWS] = '{
    '{8'd5,   8'd5,   10'd45,   1'b0}, '{8'd5, 8'd5, 10'd38, 1'b0}, '{8'd5, 8'd5, 10'd43, 1'b1},
    '{8'd2,   8'd2,   10'd43,   1'b0}, '{8'd2, 8'd2, 10'd42, 1'b0}, '{8'd2, 8'd2, 10'd30, 1'b0},
    '{8'd2,   8'd2,   10'd50,   1'b1},
    '{8'd3,   8'd2,   10'd1000, 1'b0}, '{8'd1, 8'd2, 10'd0,  1'b1},
    '{8'd7,   8'd4,   10'd0,    1'b1},
    '{8'd0,   8'd4,   10'd999,  1'b0}, '{8'd9, 8'd9, 10'd41, 1'b0}, '{8'd6, 8'd5, 10'd1000, 1'b0},
    '{8'd200, 8'd201, 10'd0,    1'b0}, '{8'd12, 8'd12, 10'd0, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        frame_start, rx_strobe, calc_req;
  logic [7:0]  rx_slot, local_slot;
  logic [9:0]  local_cycle;
  logic signed [11:0] offset;
  logic        offset_valid, rx_dropped;

  int checks = 0;
  int errors = 0;
  int m_val [DEPTH];
  int m_n = 0;
  bit done = 0;

  always #2 clk = ~clk;

  phase_offset_calc #(.SLOT_W(8), .SLOT_LEN(SLOT_LEN), .TX_DELAY(TX_DELAY), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .rx_strobe(rx_strobe),
    .rx_slot(rx_slot), .local_slot(local_slot), .local_cycle(local_cycle),
    .calc_req(calc_req), .offset(offset), .offset_valid(offset_valid),
    .rx_dropped(rx_dropped)
  );

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int model_pe(input int rs, input int ls, input int lc);
    int raw;
    raw = (rs - ls) * SLOT_LEN + TX_DELAY - lc;
    if (raw > PE_MAX) raw = PE_MAX;
    if (raw < -PE_MAX) raw = -PE_MAX;
    return raw;
  endfunction

  function automatic int model_median();
    int s [DEPTH];
    int t;
    for (int i = 0; i < DEPTH; i++) s[i] = m_val[i];
    for (int i = 0; i < m_n; i++)
      for (int j = 0; j + 1 < m_n - i; j++)
        if (s[j] > s[j+1]) begin t = s[j]; s[j] = s[j+1]; s[j+1] = t; end
    if (m_n == 0) return 0;
    return (s[(m_n-1)/2] + s[m_n/2]) / 2;
  endfunction

  task automatic send(input int rs, input int ls, input int lc);
    rx_slot = 8'(rs); local_slot = 8'(ls); local_cycle = 10'(lc);
    rx_strobe = 1'b1;
    @(negedge clk);
    rx_strobe = 1'b0;
    if (m_n < DEPTH) begin m_val[m_n] = model_pe(rs, ls, lc); m_n++; end
  endtask

  task automatic new_frame();
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    m_n = 0;
  endtask

  task automatic calc_check(input string tag);
    int exp;
    exp = model_median();
    calc_req = 1'b1;
    @(negedge clk);
    calc_req = 1'b0;
    check_eq({tag, " valid"}, int'(offset_valid), 1);
    check_eq({tag, " offset"}, int'(offset), exp);
    @(negedge clk);
    check_eq("R4 valid falls", int'(offset_valid), 0);
    check_eq("R4 offset holds", int'(offset), exp);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; frame_start = 1'b0; rx_strobe = 1'b0; calc_req = 1'b0;
    rx_slot = '0; local_slot = '0; local_cycle = '0;
    repeat (3) @(negedge clk);
    check_eq("R1 offset in reset", int'(offset), 0);
    check_eq("R1 valid in reset", int'(offset_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R1 offset after reset", int'(offset), 0);
    check_eq("R1 valid after reset", int'(offset_valid), 0);
    check_eq("R1 drop after reset", int'(rx_dropped), 0);

    // table-driven frames: R2 slot correction, R3 clipping, R6 odd, R7 even
    new_frame();
    for (int r = 0; r < NROWS; r++) begin
      send(int'(ROWS[r].rs), int'(ROWS[r].ls), int'(ROWS[r].lc));
      if (ROWS[r].last) begin
        calc_check((m_n % 2 == 1) ? "R2/R3/R6" : "R2/R7");
        new_frame();
      end
    end

    // R5: empty frame, requested twice in a row
    calc_check("R5 empty");
    calc_check("R5 repeat");

    // R9: strobe coinciding with frame start is ignored
    rx_slot = 8'd5; local_slot = 8'd5; local_cycle = 10'd0;
    rx_strobe = 1'b1;
    new_frame();
    rx_strobe = 1'b0;
    send(5, 5, 30);
    calc_check("R9 clear");

    // R8: fill to capacity, then two dropped receptions
    new_frame();
    for (int k = 1; k <= DEPTH; k++) begin
      send(5, 5, 40 - k);
      check_eq("R8 no drop below capacity", int'(rx_dropped), 0);
    end
    send(5, 5, 0);
    check_eq("R8 drop flagged", int'(rx_dropped), 1);
    send(5, 5, 0);
    check_eq("R8 second drop flagged", int'(rx_dropped), 1);
    @(negedge clk);
    check_eq("R8 drop is a pulse", int'(rx_dropped), 0);
    calc_check("R8 dropped ignored");

    done = 1;
    finish_run();
  end

endmodule